// File: doc/BRIEF.md
# Dual-Port Frame Memory with Row-Wide Serial Register

This block models a frame memory with two ways in. The random-access side has a multiplexed address and active-low row and column strobes. It supports ordinary reads and writes and bit-masked writes. The serial side is a one-row register with its own pointer and its own serial clock, so a whole row can be streamed out or in word by word. A transfer cycle moves a complete row between the array and the serial register in either direction.

Every input, strobes included, passes through a synchronizer clocked by the system clock. Strobe edges are found by comparing each synchronized sample with the one before it. When the row strobe falls, the block latches the row address. It also takes the cycle kind from the levels of the transfer/output-enable line and the mask/write-enable line. Those two lines then go back to serving as output enable and write enable for the rest of the cycle.

`ADDR_W` sets the width of both the row and the column address. The array has 2^(2·ADDR_W) words and the serial register has 2^ADDR_W words. The default is kept small so the whole array can be checked. Setting `ADDR_W = 8` gives 65,536 words of 8 bits.

Top module: `vram_dual_port`

## Requirements
- R1: The word address is the row value latched at the row-strobe fall times 2^ADDR_W plus the column value latched at each column-strobe fall. Several column strobes may follow one row strobe.
- R2: While the row strobe is high, a column strobe causes no array write, no transfer and no read drive.
- R3: The cycle kind is fixed by the levels seen at the row-strobe fall, and later changes of those lines do not alter it. A high transfer/output-enable line gives a RAM access cycle. A low one gives a transfer cycle.
- R4: In an access cycle with the mask/write-enable line high at the row-strobe fall, a column-strobe fall with that line low writes all 8 bits of `din` to the addressed word.
- R5: In an access cycle with the mask/write-enable line low at the row-strobe fall, `din` at that fall is taken as a bit mask. Later writes in the cycle change only the bits whose mask bit is 1.
- R6: A column-strobe fall with the mask/write-enable line high reads the addressed word. `dout_en` is high, and `dout` carries the word, only while the column strobe and the output-enable line are both low. Otherwise `dout` is 0.
- R7: In a transfer cycle with the mask/write-enable line high at the row-strobe fall, the column-strobe fall copies the whole addressed row into the serial register and loads the serial pointer with the column value.
- R8: In a transfer cycle with that line low, the column-strobe fall copies the serial register into the addressed row and loads the serial pointer with the column value.
- R9: Each rising serial clock with `ser_en_n` low and `ser_wr` low puts the word at the pointer on `ser_dout`. It raises `ser_dout_valid` for one cycle and advances the pointer modulo 2^ADDR_W.
- R10: Each rising serial clock with `ser_en_n` low and `ser_wr` high stores `ser_din` at the pointer and advances the pointer modulo 2^ADDR_W.
- R11: With `ser_en_n` high, serial clock edges are ignored: there is no output and the pointer does not move.
- R12: After reset, `dout_en` and `ser_dout_valid` are low, the serial pointer is 0 and the serial register holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Multiplexed row/column address |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Low at row fall: transfer cycle; afterwards: read output enable |
| wmask_we_n | input | 1 | Low at row fall: masked/write transfer; afterwards: write enable |
| ser_en_n | input | 1 | Serial port enable, active low |
| ser_clk | input | 1 | Serial clock, acts on its rising edge |
| ser_wr | input | 1 | Serial direction: 1 shifts in, 0 shifts out |
| ser_din | input | 8 | Serial input word |
| din | input | 8 | RAM write data, or write mask at the row fall |
| dout | output | 8 | RAM read data, 0 when not driven |
| dout_en | output | 1 | RAM read data valid and driven |
| ser_dout | output | 8 | Serial output word |
| ser_dout_valid | output | 1 | One-cycle pulse with each serial output word |

## Verification
The assertions assume that the row and column strobes, and the serial clock, hold each level for at least two synchronized samples. They also assume that a column strobe never falls in the same sample as the row strobe, and that a serial clock edge never lands in the cycle where a transfer loads the pointer. The stimulus meets these by changing strobe levels only a cycle after the address and control lines, and by holding every strobe level for three or more clocks. The serial clock toggles only while no column strobe is active.

// File: rtl/vram_pkg.sv
package vram_pkg;
    localparam int unsigned VR_WORD_W = 8;

    typedef enum logic [1:0] {
        CK_IDLE    = 2'd0,
        CK_ACCESS  = 2'd1,
        CK_XFER_RD = 2'd2,
        CK_XFER_WR = 2'd3
    } cyc_kind_e;
endpackage

// File: rtl/vram_in_sync.sv
module vram_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/vram_array.sv
module vram_array #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORD_W = 8
) (
    input  logic                     clk,
    input  logic [2*ADDR_W-1:0]      rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [2*ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [WORD_W-1:0]        wr_bits,
    input  logic [ADDR_W-1:0]        row_sel,
    output logic [(1<<ADDR_W)*WORD_W-1:0] row_rd,
    input  logic                     row_we,
    input  logic [(1<<ADDR_W)*WORD_W-1:0] row_wr
);
    localparam int unsigned COLS  = 1 << ADDR_W;
    localparam int unsigned DEPTH = COLS * COLS;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (row_we) begin
            for (int c = 0; c < COLS; c++) begin
                mem[{row_sel, ADDR_W'(c)}] <= row_wr[c*WORD_W +: WORD_W];
            end
        end else if (wr_en) begin
            mem[wr_addr] <= (mem[wr_addr] & ~wr_bits) | (wr_data & wr_bits);
        end
    end

    assign rd_data = mem[rd_addr];

    genvar gc;
    generate
        for (gc = 0; gc < COLS; gc++) begin : g_row_tap
            assign row_rd[gc*WORD_W +: WORD_W] = mem[{row_sel, ADDR_W'(gc)}];
        end
    endgenerate
endmodule

// File: rtl/vram_serial_reg.sv
module vram_serial_reg #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_i,
    input  logic                          wr_i,
    input  logic [WORD_W-1:0]             sdin_i,
    input  logic                          load_row_i,
    input  logic [(1<<ADDR_W)*WORD_W-1:0] row_i,
    input  logic                          ptr_load_i,
    input  logic [ADDR_W-1:0]             ptr_val_i,
    output logic [(1<<ADDR_W)*WORD_W-1:0] row_o,
    output logic [ADDR_W-1:0]             ptr_o,
    output logic [WORD_W-1:0]             sdout_o,
    output logic                          svalid_o
);
    localparam int unsigned COLS = 1 << ADDR_W;

    typedef struct packed {
        logic [COLS*WORD_W-1:0] cells;
        logic [ADDR_W-1:0]      ptr;
        logic [WORD_W-1:0]      dout;
        logic                   valid;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (step_i) begin
            if (wr_i) begin
                st_d.cells[int'(st_q.ptr)*WORD_W +: WORD_W] = sdin_i;
            end else begin
                st_d.dout  = st_q.cells[int'(st_q.ptr)*WORD_W +: WORD_W];
                st_d.valid = 1'b1;
            end
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (load_row_i) st_d.cells = row_i;
        if (ptr_load_i) st_d.ptr   = ptr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o    = st_q.cells;
    assign ptr_o    = st_q.ptr;
    assign sdout_o  = st_q.dout;
    assign svalid_o = st_q.valid;
endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
    import vram_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              xfer_oe_n,
    input  logic              wmask_we_n,
    input  logic              ser_en_n,
    input  logic              ser_clk,
    input  logic              ser_wr,
    input  logic [7:0]        ser_din,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [7:0]        ser_dout,
    output logic              ser_dout_valid
);
    localparam int unsigned W      = VR_WORD_W;
    localparam int unsigned COLS   = 1 << ADDR_W;
    localparam int unsigned BUS_W  = ADDR_W + 7 + 2*W;

    // synchronized input bundle
    logic [BUS_W-1:0]  bus_raw, bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic              ras_s, cas_s, oe_s, wm_s, sen_s, sclk_s, swr_s;
    logic [W-1:0]      sdin_s, din_s;

    assign bus_raw = {addr, ras_n, cas_n, xfer_oe_n, wmask_we_n,
                      ser_en_n, ser_clk, ser_wr, ser_din, din};

    vram_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (bus_raw),
        .sync_o (bus_s)
    );

    assign {addr_s, ras_s, cas_s, oe_s, wm_s, sen_s, sclk_s, swr_s,
            sdin_s, din_s} = bus_s;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] row;
        logic [W-1:0]      mask;
        logic              masked;
        logic [W-1:0]      rd_data;
        logic              rd_valid;
        logic              ras_p;
        logic              cas_p;
        logic              sclk_p;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    // datapath controls
    logic                 arr_we;
    logic [W-1:0]         arr_bits;
    logic                 row_we;
    logic                 sam_load;
    logic                 ptr_load;
    logic                 ser_step;
    logic [W-1:0]         arr_rd_data;
    logic [COLS*W-1:0]    arr_row;
    logic [COLS*W-1:0]    sam_row;
    logic [ADDR_W-1:0]    ser_ptr;

    logic ras_fall, ras_rise, cas_fall, cas_rise, sclk_rise;
    assign ras_fall  =  ctl_q.ras_p  & ~ras_s;
    assign ras_rise  = ~ctl_q.ras_p  &  ras_s;
    assign cas_fall  =  ctl_q.cas_p  & ~cas_s;
    assign cas_rise  = ~ctl_q.cas_p  &  cas_s;
    assign sclk_rise = ~ctl_q.sclk_p &  sclk_s;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ras_p  = ras_s;
        ctl_d.cas_p  = cas_s;
        ctl_d.sclk_p = sclk_s;
        arr_we       = 1'b0;
        arr_bits     = '1;
        row_we       = 1'b0;
        sam_load     = 1'b0;
        ptr_load     = 1'b0;
        ser_step     = sclk_rise & ~sen_s;

        if (ras_rise || ras_s) begin
            ctl_d.kind     = CK_IDLE;
            ctl_d.rd_valid = 1'b0;
        end

        if (ras_fall) begin
            ctl_d.row      = addr_s;
            ctl_d.mask     = din_s;
            ctl_d.masked   = oe_s & ~wm_s;
            ctl_d.rd_valid = 1'b0;
            if (oe_s)      ctl_d.kind = CK_ACCESS;
            else if (wm_s) ctl_d.kind = CK_XFER_RD;
            else           ctl_d.kind = CK_XFER_WR;
        end

        if (cas_fall && !ras_s) begin
            unique case (ctl_q.kind)
                CK_ACCESS: begin
                    if (!wm_s) begin
                        arr_we   = 1'b1;
                        arr_bits = ctl_q.masked ? ctl_q.mask : '1;
                    end else begin
                        ctl_d.rd_data  = arr_rd_data;
                        ctl_d.rd_valid = 1'b1;
                    end
                end
                CK_XFER_RD: begin
                    sam_load = 1'b1;
                    ptr_load = 1'b1;
                end
                CK_XFER_WR: begin
                    row_we   = 1'b1;
                    ptr_load = 1'b1;
                end
                default: ;
            endcase
        end

        if (cas_rise) ctl_d.rd_valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.kind <= CK_IDLE;
        end else begin
            ctl_q      <= ctl_d;
        end
    end

    vram_array #(.ADDR_W(ADDR_W), .WORD_W(W)) u_array (
        .clk     (clk),
        .rd_addr ({ctl_q.row, addr_s}),
        .rd_data (arr_rd_data),
        .wr_en   (arr_we),
        .wr_addr ({ctl_q.row, addr_s}),
        .wr_data (din_s),
        .wr_bits (arr_bits),
        .row_sel (ctl_q.row),
        .row_rd  (arr_row),
        .row_we  (row_we),
        .row_wr  (sam_row)
    );

    vram_serial_reg #(.ADDR_W(ADDR_W), .WORD_W(W)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (ser_step),
        .wr_i       (swr_s),
        .sdin_i     (sdin_s),
        .load_row_i (sam_load),
        .row_i      (arr_row),
        .ptr_load_i (ptr_load),
        .ptr_val_i  (addr_s),
        .row_o      (sam_row),
        .ptr_o      (ser_ptr),
        .sdout_o    (ser_dout),
        .svalid_o   (ser_dout_valid)
    );

    assign dout_en = ctl_q.rd_valid & (ctl_q.kind == CK_ACCESS) & ~cas_s & ~oe_s;
    assign dout    = dout_en ? ctl_q.rd_data : '0;
endmodule

// File: rtl/vram_dual_port_chk.sv
module vram_dual_port_chk
    import vram_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_s,
    input logic              cas_s,
    input logic              oe_s,
    input logic              arr_we,
    input logic [7:0]        arr_bits,
    input logic              masked,
    input logic              row_we,
    input cyc_kind_e         kind,
    input logic              dout_en,
    input logic [7:0]        dout,
    input logic              ser_step,
    input logic              ptr_load,
    input logic [ADDR_W-1:0] ptr,
    input logic              ser_valid
);
    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ras_s |-> !(arr_we || row_we || ptr_load));

    assert_xfer_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_XFER_RD || kind == CK_XFER_WR) |-> !(dout_en || arr_we));

    assert_full_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !masked) |-> arr_bits == 8'hFF);

    assert_dout_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!cas_s && !oe_s && kind == CK_ACCESS));

    assert_dout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == 8'h00);

    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_step && !ptr_load) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> !ser_valid);

    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_step && !ptr_load) |=> $stable(ptr));
endmodule

bind vram_dual_port vram_dual_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_s     (ras_s),
    .cas_s     (cas_s),
    .oe_s      (oe_s),
    .arr_we    (arr_we),
    .arr_bits  (arr_bits),
    .masked    (ctl_q.masked),
    .row_we    (row_we),
    .kind      (ctl_q.kind),
    .dout_en   (dout_en),
    .dout      (dout),
    .ser_step  (ser_step),
    .ptr_load  (ptr_load),
    .ptr       (ser_ptr),
    .ser_valid (ser_dout_valid)
);

// File: tb/vram_dual_port_test.sv
`timescale 1ns/1ps
module vram_dual_port_test;
    localparam int AW   = 5;
    localparam int COLS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ras_n = 1'b1, cas_n = 1'b1, xfer_oe_n = 1'b1, wmask_we_n = 1'b1;
    logic          ser_en_n = 1'b1, ser_clk = 1'b0, ser_wr = 1'b0;
    logic [7:0]    ser_din = '0, din = '0;
    logic [7:0]    dout, ser_dout;
    logic          dout_en, ser_dout_valid;

    always #4 clk = ~clk;

    vram_dual_port #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .xfer_oe_n(xfer_oe_n), .wmask_we_n(wmask_we_n), .ser_en_n(ser_en_n),
        .ser_clk(ser_clk), .ser_wr(ser_wr), .ser_din(ser_din), .din(din),
        .dout(dout), .dout_en(dout_en), .ser_dout(ser_dout),
        .ser_dout_valid(ser_dout_valid)
    );

    int nchk = 0, nfail = 0;
    logic [7:0] ref_mem [COLS*COLS];
    logic [7:0] ref_sam [COLS];
    int         ref_ptr = 0;
    logic [7:0] rd_q[$];  string rd_tag[$];
    logic [7:0] sr_q[$];  string sr_tag[$];
    int         ser_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // scoreboard monitor
    logic en_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_en && !en_prev) begin
                if (rd_q.size() == 0) chk(0, "R2 R6 unexpected read drive", dout, 0);
                else begin
                    automatic logic [7:0] e = rd_q.pop_front();
                    automatic string t = rd_tag.pop_front();
                    chk(dout == e, t, dout, e);
                end
            end
            if (ser_dout_valid) begin
                ser_seen++;
                if (sr_q.size() == 0) chk(0, "R11 unexpected serial word", ser_dout, 0);
                else begin
                    automatic logic [7:0] e = sr_q.pop_front();
                    automatic string t = sr_tag.pop_front();
                    chk(ser_dout == e, t, ser_dout, e);
                end
            end
        end
        en_prev = dout_en;
    end

    // driver tasks
    task automatic row_open(input int row, input bit xfer_oe, input bit wm, input logic [7:0] m);
        addr = AW'(row); xfer_oe_n = xfer_oe; wmask_we_n = wm; din = m;
        tick(1);
        ras_n = 1'b0;
        tick(4);
        xfer_oe_n = 1'b1; wmask_we_n = 1'b1;
        tick(1);
    endtask

    task automatic row_close();
        ras_n = 1'b1;
        tick(4);
    endtask

    task automatic cas_write(input int col, input logic [7:0] d);
        addr = AW'(col); din = d; wmask_we_n = 1'b0; xfer_oe_n = 1'b1;
        tick(1);
        cas_n = 1'b0;
        tick(5);
        cas_n = 1'b1; wmask_we_n = 1'b1;
        tick(4);
    endtask

    task automatic cas_read(input int row, input int col, input string tag);
        rd_q.push_back(ref_mem[row*COLS + col]); rd_tag.push_back(tag);
        addr = AW'(col); wmask_we_n = 1'b1; xfer_oe_n = 1'b0;
        tick(1);
        cas_n = 1'b0;
        tick(6);
        cas_n = 1'b1; xfer_oe_n = 1'b1;
        tick(4);
    endtask

    task automatic cas_plain(input int col);
        addr = AW'(col);
        tick(1);
        cas_n = 1'b0;
        tick(5);
        cas_n = 1'b1;
        tick(4);
    endtask

    task automatic ser_pulse();
        ser_clk = 1'b1; tick(3);
        ser_clk = 1'b0; tick(3);
    endtask

    task automatic ser_out(input string tag);
        ser_en_n = 1'b0; ser_wr = 1'b0;
        sr_q.push_back(ref_sam[ref_ptr]); sr_tag.push_back(tag);
        ref_ptr = (ref_ptr + 1) % COLS;
        ser_pulse();
    endtask

    task automatic ser_in(input logic [7:0] d);
        ser_en_n = 1'b0; ser_wr = 1'b1; ser_din = d;
        ref_sam[ref_ptr] = d;
        ref_ptr = (ref_ptr + 1) % COLS;
        ser_pulse();
        ser_wr = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'((r*37 + c*11) ^ 8'h5A);
    endfunction

    task automatic finish_run();
        tick(20);
        chk(rd_q.size() == 0, "R6 read results outstanding", rd_q.size(), 0);
        chk(sr_q.size() == 0, "R9 serial results outstanding", sr_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int seen0;
        for (int i = 0; i < COLS; i++) ref_sam[i] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R12: reset state
        chk(dout_en == 1'b0, "R12 dout_en after reset", dout_en, 0);
        chk(ser_dout_valid == 1'b0, "R12 ser_dout_valid after reset", ser_dout_valid, 0);
        ser_out("R12 serial register cleared, pointer 0");
        ser_out("R12 serial register cleared, pointer 1");
        ser_en_n = 1'b1;

        // R4 R1: fill every word with normal writes, one row strobe per row
        for (int r = 0; r < COLS; r++) begin
            row_open(r, 1'b1, 1'b1, 8'h00);
            for (int c = 0; c < COLS; c++) begin
                cas_write(c, pat(r, c));
                ref_mem[r*COLS + c] = pat(r, c);
            end
            row_close();
        end

        // R2: column strobe with write enable while row strobe is high
        addr = AW'(3); din = 8'hFF; wmask_we_n = 1'b0; xfer_oe_n = 1'b0;
        tick(1);
        cas_n = 1'b0; tick(6);
        chk(dout_en == 1'b0, "R2 no read drive in standby", dout_en, 0);
        cas_n = 1'b1; wmask_we_n = 1'b1; xfer_oe_n = 1'b1; tick(4);

        // R1 R6 R3: exhaustive read-back (output enable held low mid-cycle keeps the access kind)
        for (int r = 0; r < COLS; r++) begin
            row_open(r, 1'b1, 1'b1, 8'h00);
            for (int c = 0; c < COLS; c++) cas_read(r, c, "R1 R6 read-back");
            row_close();
        end
        row_open(0, 1'b1, 1'b1, 8'h00);
        cas_read(0, 3, "R2 standby write left word unchanged");
        row_close();

        // R5: masked write, mask F0 taken at row fall
        row_open(2, 1'b1, 1'b0, 8'hF0);
        cas_write(5, 8'hAB);
        ref_mem[2*COLS + 5] = (ref_mem[2*COLS + 5] & 8'h0F) | (8'hAB & 8'hF0);
        cas_write(6, 8'h0F);
        ref_mem[2*COLS + 6] = (ref_mem[2*COLS + 6] & 8'h0F);
        row_close();
        row_open(2, 1'b1, 1'b1, 8'h00);
        cas_read(2, 5, "R5 masked write upper nibble");
        cas_read(2, 6, "R5 masked write keeps low bits");
        cas_read(2, 7, "R5 neighbour untouched");
        row_close();

        // R7 R3 R9: read transfer row 9, column 30, then stream across the wrap
        row_open(9, 1'b0, 1'b1, 8'h00);
        cas_plain(30);
        row_close();
        for (int c = 0; c < COLS; c++) ref_sam[c] = ref_mem[9*COLS + c];
        ref_ptr = 30;
        for (int k = 0; k < 5; k++) ser_out("R7 R9 serial out with wraparound");

        // R11: serial clocks with the port disabled
        seen0 = ser_seen;
        ser_en_n = 1'b1;
        for (int k = 0; k < 3; k++) ser_pulse();
        chk(ser_seen == seen0, "R11 no serial output while disabled", ser_seen - seen0, 0);
        ser_out("R11 pointer held while disabled");
        ser_out("R11 pointer held while disabled");

        // R10: shift a full row in from the current pointer
        for (int k = 0; k < COLS; k++) ser_in(8'(8'hC0 + k));
        ser_en_n = 1'b1;

        // R8: write transfer into row 4, column 7
        row_open(4, 1'b0, 1'b0, 8'h00);
        cas_plain(7);
        row_close();
        for (int c = 0; c < COLS; c++) ref_mem[4*COLS + c] = ref_sam[c];
        ref_ptr = 7;
        ser_out("R8 pointer loaded by write transfer");
        ser_out("R8 pointer loaded by write transfer");
        ser_en_n = 1'b1;
        row_open(4, 1'b1, 1'b1, 8'h00);
        for (int c = 0; c < COLS; c++) cas_read(4, c, "R8 R10 row written from serial register");
        row_close();
        row_open(5, 1'b1, 1'b1, 8'h00);
        cas_read(5, 0, "R8 next row untouched");
        row_close();

        finish_run();
    end
endmodule